// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the register front end of an I/O interrupt controller. Software reaches it through a small bus slave with two live offsets: a 32-bit select register, and a data window that opens whichever internal register the select value names. Behind the window sit a 4-bit controller identifier, a read-only version word, and a redirection table with one 64-bit entry per interrupt input. Each entry is reached as two 32-bit halves.

The whole table is exported as a flat vector, so the interrupt logic next to the block can read vector, delivery mode, destination, polarity, trigger mode and mask for every pin. The interrupt logic sets each entry's remote-IRR status bit through a per-pin strobe. When an entry has been written, the block pulses a write strobe with the pin number. If that pin's request line was pending when the write happened, it also raises a service request in the same cycle. Servicing and delivery are left to the neighbouring logic.

Top module: `irq_regwin`

## Requirements
- R1: Only address bits 7:0 are decoded. Offset 0x00 is the select register, which is written whole from data bits 31:0 and read back whole. Offset 0x10 is the data window. Any other offset reads 0 and ignores writes.
- R2: Select value 0x01 reads the version word: (pin count − 1) in bits 23:16, the version code (default 0x11) in bits 7:0, all other bits 0. Writes to it change nothing.
- R3: Select value 0x00 reads the 4-bit controller ID in bits 27:24, and a window write there loads data bits 27:24 into the ID. Select 0x02 reads the same ID, and writes to select 0x02 are ignored.
- R4: For a select value S ≥ 0x10, the window reaches table entry (S − 0x10) >> 1. An odd S maps to entry bits 63:32 and an even S to bits 31:0. Select values 0x03 to 0x0F, and table selects whose entry index is at or beyond the pin count, read 0.
- R5: A write to the low half of an entry stores the data but forces the remote-IRR bit (bit 14) to 0. A write to the high half leaves bits 31:0 unchanged.
- R6: A table write whose entry index is at or beyond the pin count changes no entry and produces no write strobe.
- R7: One cycle after an accepted table write, `wr_strobe` is 1 and `wr_pin` holds the entry index. `svc_req` is 1 in that same cycle exactly when `irq_pending` for that pin was 1 during the write cycle. With no accepted table write, both are 0.
- R8: Writes with `bus_len` 4 or 8 use data bits 31:0, and all other lengths are dropped. Reads with length 1 or 2 return only the low 1 or 2 bytes. Reads with length 4 or 8 return the full 32-bit word. Any other length reads 0.
- R9: After reset, every entry equals 0x0000_0000_0001_0000 (mask bit 16 set), and both the select register and the ID are 0.
- R10: A `rirr_set` bit sets bit 14 of that pin's entry. If a low-half write hits the same entry in the same cycle, the write wins and bit 14 ends at 0.
- R11: Entry i appears on `tbl_flat[64*i+63 : 64*i]` in the cycle after it is written. Field layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote IRR 14, trigger mode 15 (1 = level), mask 16, destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (32) | Byte address; only bits 7:0 decoded |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 64 | Write data; bits 31:0 used |
| bus_len | input | 4 | Access length in bytes |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_pending | input | NPINS (24) | Per-pin request status from the interrupt logic |
| rirr_set | input | NPINS (24) | Per-pin strobe that sets remote IRR |
| tbl_flat | output | NPINS*64 | All table entries, entry i at bits 64i+63:64i |
| wr_strobe | output | 1 | An entry was written in the previous cycle |
| wr_pin | output | IDX_W (5) | Index of that entry |
| svc_req | output | 1 | Service request for `wr_pin` |

## Verification
Two functions can land on the same entry in one cycle: the interrupt logic setting remote IRR through `rirr_set`, and a software write to the entry's low half that must clear that bit. The bench drives both in one cycle, and also pairs the set with a high-half write, where the set must survive. The resulting bit 14 is judged on `tbl_flat` and through a window read. A second overlap comes from table writes made while the pin's `irq_pending` is high or low, with the strobe and service request compared against the reference model in the following cycle.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam int unsigned RIRR_BIT  = 14;
  localparam int unsigned MASK_BIT  = 16;
  localparam logic [63:0] ENTRY_RST = 64'h1 << MASK_BIT;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;

  localparam logic [31:0] SEL_ID     = 32'h0;
  localparam logic [31:0] SEL_VER    = 32'h1;
  localparam logic [31:0] SEL_ARB    = 32'h2;
  localparam logic [31:0] SEL_TABLE0 = 32'h10;

  typedef enum logic [1:0] {TGT_NONE, TGT_SEL, TGT_WIN} tgt_e;
  typedef enum logic [1:0] {WK_ID, WK_VER, WK_TBL, WK_ZERO} wkind_e;

  function automatic logic [31:0] version_word(input int npins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

  function automatic logic wr_len_ok(input logic [3:0] len);
    return (len == 4'd4) || (len == 4'd8);
  endfunction

  function automatic logic [31:0] trim_read(input logic [31:0] v, input logic [3:0] len);
    logic [31:0] r;
    case (len)
      4'd1:       r = {24'h0, v[7:0]};
      4'd2:       r = {16'h0, v[15:0]};
      4'd4, 4'd8: r = v;
      default:    r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] table_slot(input logic [31:0] sel);
    return (sel - SEL_TABLE0) >> 1;
  endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [3:0]        len,
  input  logic [31:0]       sel,
  output tgt_e              tgt,
  output wkind_e            kind,
  output logic [IDX_W-1:0]  idx,
  output logic              hi_half,
  output logic              wr_sel,
  output logic              wr_id,
  output logic              wr_lo,
  output logic              wr_hi
);

  logic [7:0]  off;
  logic [31:0] slot;
  logic        tbl_sel;
  logic        in_rng;
  logic        wr_ok;
  logic        unused_addr;

  assign off         = addr[7:0];
  assign unused_addr = ^addr[ADDR_W-1:8];

  always_comb begin
    if (off == OFF_SELECT)      tgt = TGT_SEL;
    else if (off == OFF_WINDOW) tgt = TGT_WIN;
    else                        tgt = TGT_NONE;
  end

  assign slot    = table_slot(sel);
  assign tbl_sel = (sel >= SEL_TABLE0);
  assign in_rng  = tbl_sel && (slot < 32'(NPINS));
  assign idx     = slot[IDX_W-1:0];
  assign hi_half = sel[0];

  always_comb begin
    if (sel == SEL_ID || sel == SEL_ARB) kind = WK_ID;
    else if (sel == SEL_VER)             kind = WK_VER;
    else if (in_rng)                     kind = WK_TBL;
    else                                 kind = WK_ZERO;
  end

  assign wr_ok  = wr && wr_len_ok(len);
  assign wr_sel = wr_ok && (tgt == TGT_SEL);
  assign wr_id  = wr_ok && (tgt == TGT_WIN) && (sel == SEL_ID);
  assign wr_lo  = wr_ok && (tgt == TGT_WIN) && in_rng && !sel[0];
  assign wr_hi  = wr_ok && (tgt == TGT_WIN) && in_rng &&  sel[0];

  // R8: a write of an unsupported length must not reach any register
  p_wr_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel || wr_id || wr_lo || wr_hi) |-> (len == 4'd4 || len == 4'd8));

  // R6: table strobes only for entries that exist
  p_oob_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |-> (32'(idx) < 32'(NPINS)));

  // write strobes are mutually exclusive
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_sel, wr_id, wr_lo, wr_hi}));

endmodule

// File: rtl/irw_entry.sv
module irw_entry
  import irw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] q
);

  logic [63:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_hi) nxt[63:32] = wdata;
    if (wr_lo) begin
      nxt[31:0]     = wdata;
      nxt[RIRR_BIT] = 1'b0;
    end else if (rirr_set) begin
      nxt[RIRR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= ENTRY_RST;
    else        q <= nxt;
  end

  // R5: low-half write leaves remote IRR clear
  p_lo_clears_rirr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !q[RIRR_BIT]);

  // R5: high-half write keeps everything in the low half except the status bit
  p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> ({q[31:RIRR_BIT+1], q[RIRR_BIT-1:0]} ==
                           $past({q[31:RIRR_BIT+1], q[RIRR_BIT-1:0]})));

  // R10: set strobe takes effect unless a low write competes
  p_rirr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set && !wr_lo) |=> q[RIRR_BIT]);

  // R11: no write means the high half holds
  p_hold_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(q[63:32]));

endmodule

// File: rtl/irw_readmux.sv
module irw_readmux
  import irw_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  tgt_e                   tgt,
  input  wkind_e                 kind,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   hi_half,
  input  logic [31:0]            sel,
  input  logic [3:0]             id,
  input  logic [3:0]             len,
  input  logic [NPINS*64-1:0]    tbl,
  output logic [31:0]            rdata
);

  logic [IDX_W-1:0] eff_idx;
  logic [IDX_W+5:0] bitpos;
  logic [31:0]      tbl_word;
  logic [31:0]      win_word;
  logic [31:0]      raw;

  assign eff_idx  = (kind == WK_TBL) ? idx : '0;
  assign bitpos   = {eff_idx, hi_half, 5'b0};
  assign tbl_word = tbl[bitpos +: 32];

  always_comb begin
    case (kind)
      WK_ID:   win_word = {4'h0, id, 24'h0};
      WK_VER:  win_word = version_word(NPINS, VERSION);
      WK_TBL:  win_word = tbl_word;
      default: win_word = 32'h0;
    endcase
  end

  always_comb begin
    case (tgt)
      TGT_SEL: raw = sel;
      TGT_WIN: raw = win_word;
      default: raw = 32'h0;
    endcase
  end

  assign rdata = trim_read(raw, len);

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irw_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 32,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [63:0]         bus_wdata,
  input  logic [3:0]          bus_len,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    irq_pending,
  input  logic [NPINS-1:0]    rirr_set,
  output logic [NPINS*64-1:0] tbl_flat,
  output logic                wr_strobe,
  output logic [IDX_W-1:0]    wr_pin,
  output logic                svc_req
);

  logic [31:0]      sel_q;
  logic [3:0]       id_q;
  logic [31:0]      wd;
  logic             unused_wd_hi;

  tgt_e             dec_tgt;
  wkind_e           dec_kind;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_hi;
  logic             dec_wr_sel;
  logic             dec_wr_id;
  logic             dec_wr_lo;
  logic             dec_wr_hi;
  logic             tbl_write;
  logic             pend_hit;

  assign wd           = bus_wdata[31:0];
  assign unused_wd_hi = ^bus_wdata[63:32];

  irw_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .len     (bus_len),
    .sel     (sel_q),
    .tgt     (dec_tgt),
    .kind    (dec_kind),
    .idx     (dec_idx),
    .hi_half (dec_hi),
    .wr_sel  (dec_wr_sel),
    .wr_id   (dec_wr_id),
    .wr_lo   (dec_wr_lo),
    .wr_hi   (dec_wr_hi)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic        hit;
    logic [63:0] q;
    assign hit = (dec_idx == IDX_W'(g));
    irw_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (dec_wr_lo && hit),
      .wr_hi    (dec_wr_hi && hit),
      .wdata    (wd),
      .rirr_set (rirr_set[g]),
      .q        (q)
    );
    assign tbl_flat[g*64 +: 64] = q;
  end

  irw_readmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
    .tgt     (dec_tgt),
    .kind    (dec_kind),
    .idx     (dec_idx),
    .hi_half (dec_hi),
    .sel     (sel_q),
    .id      (id_q),
    .len     (bus_len),
    .tbl     (tbl_flat),
    .rdata   (bus_rdata)
  );

  assign tbl_write = dec_wr_lo || dec_wr_hi;
  assign pend_hit  = irq_pending[dec_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      wr_strobe <= 1'b0;
      wr_pin    <= '0;
      svc_req   <= 1'b0;
    end else begin
      if (dec_wr_sel) sel_q <= wd;
      if (dec_wr_id)  id_q  <= wd[27:24];
      wr_strobe <= tbl_write;
      if (tbl_write) wr_pin <= dec_idx;
      svc_req   <= tbl_write && pend_hit;
    end
  end

  // R7: a service request only accompanies a write strobe
  p_svc_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> wr_strobe);

  // R7: a strobe traces back to a bus write of a legal length
  p_strobe_from_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(bus_wr && (bus_len == 4'd4 || bus_len == 4'd8)));

  // R3: the ID changes only through its own window write
  p_id_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_wr_id |=> $stable(id_q));

  // R1: the select register changes only through offset 0x00
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_wr_sel |=> $stable(sel_q));

endmodule

// File: tb/tb_irq_regwin.sv
`timescale 1ns/1ps
module tb_irq_regwin;

  localparam int NP = 24;
  localparam int TW = NP * 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [63:0]   bus_wdata = '0;
  logic [3:0]    bus_len = 4'd4;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] irq_pending = '0;
  logic [NP-1:0] rirr_set = '0;
  logic [TW-1:0] tbl_flat;
  logic          wr_strobe;
  logic [4:0]    wr_pin;
  logic          svc_req;

  always #4 clk = ~clk;

  irq_regwin dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_len(bus_len), .bus_rdata(bus_rdata),
    .irq_pending(irq_pending), .rirr_set(rirr_set), .tbl_flat(tbl_flat),
    .wr_strobe(wr_strobe), .wr_pin(wr_pin), .svc_req(svc_req)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_tbl [NP];
  logic [31:0] m_sel;
  logic [3:0]  m_id;
  bit          e_strobe, e_svc;
  int          e_pin;

  task automatic chk(string req, string what, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [31:0] a, logic [3:0] len);
    logic [31:0] w;
    int o, s;
    o = int'(a & 32'hFF);
    s = int'(m_sel);
    w = 0;
    if (o == 0) w = m_sel;
    else if (o == 16) begin
      if (m_sel == 0 || m_sel == 2) w = {4'h0, m_id, 24'h0};
      else if (m_sel == 1) w = 32'h0000_0011 | ((NP - 1) << 16);
      else if (m_sel >= 16 && m_sel < 16 + 2 * NP) begin
        if (s % 2 == 1) w = m_tbl[(s - 16) / 2][63:32];
        else            w = m_tbl[(s - 16) / 2][31:0];
      end
    end
    if (len == 1)                 return w & 32'hFF;
    else if (len == 2)            return w & 32'hFFFF;
    else if (len == 4 || len == 8) return w;
    return 0;
  endfunction

  function automatic logic [TW-1:0] m_flat();
    logic [TW-1:0] f;
    for (int i = 0; i < NP; i++) f[i*64 +: 64] = m_tbl[i];
    return f;
  endfunction

  task automatic m_step(logic [31:0] a, bit w, logic [63:0] d, logic [3:0] len,
                        logic [NP-1:0] pend, logic [NP-1:0] rs);
    int o, s, ix;
    o = int'(a & 32'hFF);
    e_strobe = 0;
    e_svc = 0;
    for (int i = 0; i < NP; i++) if (rs[i]) m_tbl[i][14] = 1'b1;
    if (w && (len == 4 || len == 8)) begin
      if (o == 0) m_sel = d[31:0];
      else if (o == 16) begin
        if (m_sel == 0) m_id = d[27:24];
        else if (m_sel >= 16 && m_sel < 16 + 2 * NP) begin
          s = int'(m_sel);
          ix = (s - 16) / 2;
          if (s % 2 == 1) m_tbl[ix][63:32] = d[31:0];
          else begin
            m_tbl[ix][31:0] = d[31:0];
            m_tbl[ix][14] = 1'b0;
          end
          e_strobe = 1;
          e_pin = ix;
          e_svc = pend[ix];
        end
      end
    end
  endtask

  // one bus cycle: inputs driven after the falling edge, combinational read
  // checked before the rising edge, registered outputs checked after it
  task automatic cyc(string req, logic [31:0] a, bit w, logic [63:0] d, logic [3:0] len,
                     logic [NP-1:0] pend = '0, logic [NP-1:0] rs = '0);
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_len = len;
    irq_pending = pend; rirr_set = rs;
    #1;
    chk(req, "rdata", TW'(bus_rdata), TW'(m_read(a, len)));
    @(posedge clk);
    m_step(a, w, d, len, pend, rs);
    #1;
    chk(req, "table", tbl_flat, m_flat());
    chk(req, "strobe", TW'(wr_strobe), TW'(e_strobe));
    chk(req, "svc", TW'(svc_req), TW'(e_svc));
    if (e_strobe) chk(req, "pin", TW'(wr_pin), TW'(e_pin));
    @(negedge clk);
  endtask

  task automatic rd(string req, logic [31:0] a, logic [3:0] len = 4'd4);
    cyc(req, a, 1'b0, 64'h0, len);
  endtask

  task automatic wrt(string req, logic [31:0] a, logic [63:0] d, logic [3:0] len = 4'd4,
                     logic [NP-1:0] pend = '0, logic [NP-1:0] rs = '0);
    cyc(req, a, 1'b1, d, len, pend, rs);
  endtask

  localparam logic [31:0] SELA = 32'hFEC0_0000;
  localparam logic [31:0] WINA = 32'hFEC0_0010;

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) m_tbl[i] = 64'h1_0000;
    m_sel = 0; m_id = 0; e_strobe = 0; e_svc = 0; e_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state of table, select and ID
    rd("R9", SELA);
    rd("R9", WINA);
    wrt("R9", SELA, 64'h10);
    rd("R9", WINA);

    // R1: upper address bits ignored, stray offsets inert
    wrt("R1", 32'h1234_5600, 64'hDEAD_BEEF_0000_0013);
    rd("R1", 32'h0000_0000);
    rd("R1", 32'hFEC0_0020);
    wrt("R1", 32'hFEC0_0020, 64'h55);
    wrt("R1", 32'hFEC0_0004, 64'h77);
    rd("R1", SELA);

    // R2: version word
    wrt("R2", SELA, 64'h1);
    rd("R2", WINA);
    wrt("R2", WINA, 64'hFFFF_FFFF);
    rd("R2", WINA);

    // R3: ID and arbitration aliases
    wrt("R3", SELA, 64'h0);
    wrt("R3", WINA, 64'hA500_0000);
    rd("R3", WINA);
    wrt("R3", SELA, 64'h2);
    rd("R3", WINA);
    wrt("R3", WINA, 64'h0F00_0000);
    wrt("R3", SELA, 64'h0);
    rd("R3", WINA);

    // R4 / R5 / R11: halves, status clear, high write leaves low alone
    wrt("R5", SELA, 64'h10);
    wrt("R5", WINA, 64'hFFFF_FFFF);
    rd("R5", WINA);
    wrt("R4", SELA, 64'h11);
    wrt("R4", WINA, 64'hAB00_0000);
    rd("R4", WINA);
    wrt("R5", SELA, 64'h10);
    rd("R5", WINA);
    wrt("R11", SELA, 64'h3E);
    wrt("R11", WINA, 64'h0000_A031);
    wrt("R11", SELA, 64'h3F);
    wrt("R11", WINA, 64'h7700_0000);
    rd("R11", WINA);
    wrt("R4", SELA, 64'h05);
    rd("R4", WINA);

    // R6: index at the pin count and beyond
    wrt("R6", SELA, 64'h40);
    wrt("R6", WINA, 64'h1234_5678);
    rd("R6", WINA);
    wrt("R6", SELA, 64'h41);
    wrt("R6", WINA, 64'h1234_5678, 4'd8, '1);
    wrt("R6", SELA, 64'hFFFF_FFF0);
    wrt("R6", WINA, 64'h1);

    // R8: write and read lengths
    wrt("R8", SELA, 64'h12);
    wrt("R8", WINA, 64'h0000_00AA, 4'd2);
    wrt("R8", WINA, 64'h0000_00AA, 4'd1);
    rd("R8", WINA);
    wrt("R8", WINA, 64'hFFFF_FFFF_0102_8384, 4'd8);
    rd("R8", WINA, 4'd1);
    rd("R8", WINA, 4'd2);
    rd("R8", WINA, 4'd8);
    rd("R8", WINA, 4'd3);
    rd("R8", SELA, 4'd1);

    // R7: strobe, pin and service request
    wrt("R7", SELA, 64'h14);
    wrt("R7", WINA, 64'h41, 4'd4, NP'(1) << 2);
    wrt("R7", WINA, 64'h42, 4'd4, ~(NP'(1) << 2));
    wrt("R7", SELA, 64'h15);
    wrt("R7", WINA, 64'h0100_0000, 4'd4, NP'(1) << 2);
    rd("R7", WINA);

    // R10: set strobe, then set racing a low write, then set with a high write
    rd("R10", SELA, 4'd4);
    cyc("R10", WINA, 1'b0, 64'h0, 4'd4, '0, NP'(1) << 3);
    wrt("R10", SELA, 64'h16);
    rd("R10", WINA);
    wrt("R10", WINA, 64'h0000_4099, 4'd4, '0, NP'(1) << 3);
    rd("R10", WINA);
    wrt("R10", SELA, 64'h17);
    wrt("R10", WINA, 64'h0F00_0000, 4'd4, '0, NP'(1) << 3);
    wrt("R10", SELA, 64'h16);
    rd("R10", WINA);

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic [63:0] d;
      logic [3:0]  l;
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0, 1:    a = SELA;
        2, 3:    a = WINA;
        4:       a = 32'h0000_0110;
        5:       a = 32'h0000_0020;
        default: a = 32'h0000_0004;
      endcase
      if (pick <= 1) d = 64'($urandom_range(0, 8'h42));
      else           d = {$urandom, $urandom};
      case ($urandom_range(0, 5))
        0: l = 4'd1; 1: l = 4'd2; 2: l = 4'd3; 3: l = 4'd8;
        default: l = 4'd4;
      endcase
      cyc((pick <= 1) ? "R1" : "R11", a, bit'($urandom_range(0, 1)), d, l,
          NP'($urandom), ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule